// File: doc/BRIEF.md
# Downstream Port Reset Output Generator

This block drives one active-low reset output for each downstream port of a switch. Each output reaches the board through a pin that it shares with a general-purpose input. The pin stays tri-stated until the reset-output function is selected for that port. A single mode field chooses what asserts every port's reset:

- the slot power-on control bit,
- a power-good indication from the slot,
- the port's hot-reset state.

The power-good and hot-reset inputs arrive from outside the clock domain, so each passes through a two-flop synchroniser first. Whatever the selected source does, a per-port down-counter keeps the reset asserted for a minimum number of clock cycles. The default is sized for 200 µs at 250 MHz. The counter is loaded only when a new assertion begins. Release happens once the counter has run out and the source is inactive. The ports share nothing except the mode field.

Top module: `prg_port_reset`

## Requirements
- R1: While the fundamental reset `rst_n` is low, every `rst_pin_oe` bit is 0 and every `rst_pin_o` bit is 0. After release, the outputs return to 1 within MIN_ASSERT_CYCLES+4 cycles when no source is active.
- R2: `rst_pin_oe[i]` equals `alt_fn_en[i]` as sampled at the previous clock edge. It is 0 while `alt_fn_en[i]` is 0.
- R3: With `mode_sel` = 0, the reset of port i is asserted (`rst_pin_o[i]` = 0) one cycle after `slot_pwr_on[i]` goes to 0. It stays asserted while that bit is 0.
- R4: With `mode_sel` = 1, the reset of port i is asserted three cycles after `pwr_good[i]` falls, because of the two synchroniser flops. It is released three cycles after `pwr_good[i]` rises, provided the minimum width has run out. `slot_pwr_on` has no effect in this mode.
- R5: With `mode_sel` = 2, the reset of port i is asserted three cycles after `hot_reset[i]` rises. It is released three cycles after `hot_reset[i]` falls, provided the minimum width has run out.
- R6: `mode_sel` = 3 behaves exactly like `mode_sel` = 0.
- R7: Once asserted, an output stays at 0 for at least MIN_ASSERT_CYCLES+1 consecutive cycles. A source pulse shorter than that gives exactly MIN_ASSERT_CYCLES+1 cycles.
- R8: When the source goes inactive in the very cycle the minimum-width counter reaches zero, the output is released on the next edge. No extra cycle is added.
- R9: The minimum-width counter loads only when a new assertion begins. A source held active longer than the window releases the output one edge after the source is seen inactive.
- R10: The ports operate independently. Activity on one port's source changes neither the pin nor the output enable of another port.
- R11: The pin value follows the reset state even while `rst_pin_oe` is 0. Disabling the output does not change the reset behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Fundamental reset, active low; asserted asynchronously, released synchronously inside |
| mode_sel | input | 2 | Reset source select: 0 power-on bit, 1 power-good, 2 hot-reset, 3 same as 0 |
| slot_pwr_on | input | NUM_PORTS | Slot power control bit per port (1 = power on), synchronous |
| pwr_good | input | NUM_PORTS | Slot power-good per port, asynchronous |
| hot_reset | input | NUM_PORTS | Hot-reset state per port, asynchronous, active high |
| alt_fn_en | input | NUM_PORTS | Selects the reset-output function on each shared pin |
| rst_pin_o | output | NUM_PORTS | Reset pin value per port, active low |
| rst_pin_oe | output | NUM_PORTS | Pin output enable per port |

## Verification
Two functions can meet in a single cycle: the minimum-width counter reaching zero, and the selected source going inactive. The bench sets the power-on bit low and restores it exactly on the cycle the counter empties. It then checks that release comes on the next edge, at the same point as for a one-cycle pulse. The scoreboard also compares two other cases at fixed cycles against the same MIN_ASSERT_CYCLES+1 width: sources held far beyond the window, and short pulses through the synchronised paths.

// File: rtl/prg_pkg.sv
package prg_pkg;
  typedef enum logic [1:0] {
    SRC_PWR_ON   = 2'd0,
    SRC_PWR_GOOD = 2'd1,
    SRC_HOT_RST  = 2'd2,
    SRC_SPARE    = 2'd3
  } src_mode_e;
endpackage

// File: rtl/prg_sync2.sv
module prg_sync2 #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/prg_port_ctl.sv
module prg_port_ctl #(
  parameter int MIN_CYC = 50000,
  localparam int CW = $clog2(MIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_active,
  output logic asserted_o
);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

  logic          asrt_q, asrt_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // next state
  always_comb begin
    asrt_d = asrt_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!asrt_q) begin
      if (src_active) begin
        asrt_d = 1'b1;
        cnt_d  = MIN_V;
        cnt_en = 1'b1;
      end
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_en = 1'b1;
    end else if (!src_active) begin
      asrt_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asrt_q <= 1'b1;
      cnt_q  <= MIN_V;
    end else begin
      asrt_q <= asrt_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign asserted_o = asrt_q;

  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asrt_q) |-> ($past(cnt_q) == '0)); // R7
  AST_RELOAD_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asrt_q) |-> (cnt_q == MIN_V)); // R9
  AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (asrt_q && src_active) |=> asrt_q); // R3
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MIN_V); // R7
  AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (asrt_q && cnt_q == '0 && !src_active) |=> !asrt_q); // R8
endmodule

// File: rtl/prg_port_reset.sv
module prg_port_reset
  import prg_pkg::*;
#(
  parameter int NUM_PORTS         = 3,
  parameter int MIN_ASSERT_CYCLES = 50000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic [NUM_PORTS-1:0] slot_pwr_on,
  input  logic [NUM_PORTS-1:0] pwr_good,
  input  logic [NUM_PORTS-1:0] hot_reset,
  input  logic [NUM_PORTS-1:0] alt_fn_en,
  output logic [NUM_PORTS-1:0] rst_pin_o,
  output logic [NUM_PORTS-1:0] rst_pin_oe
);
  logic [1:0]           rst_pipe_q;
  logic                 rst_n_s;
  logic [NUM_PORTS-1:0] pg_s;
  logic [NUM_PORTS-1:0] hr_s;
  logic [NUM_PORTS-1:0] src_act;
  logic [NUM_PORTS-1:0] asserted;
  logic [NUM_PORTS-1:0] oe_q;
  src_mode_e            mode;

  // reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  prg_sync2 #(.W(NUM_PORTS), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .rst_n(rst_n_s), .d(pwr_good), .q(pg_s)
  );
  prg_sync2 #(.W(NUM_PORTS), .RST_VAL(1'b1)) u_hr_sync (
    .clk(clk), .rst_n(rst_n_s), .d(hot_reset), .q(hr_s)
  );

  assign mode = src_mode_e'(mode_sel);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    always_comb begin
      case (mode)
        SRC_PWR_GOOD: src_act[i] = ~pg_s[i];
        SRC_HOT_RST:  src_act[i] = hr_s[i];
        default:      src_act[i] = ~slot_pwr_on[i];
      endcase
    end

    prg_port_ctl #(.MIN_CYC(MIN_ASSERT_CYCLES)) u_ctl (
      .clk(clk), .rst_n(rst_n_s), .src_active(src_act[i]), .asserted_o(asserted[i])
    );

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) oe_q[i] <= 1'b0;
      else          oe_q[i] <= alt_fn_en[i];
    end

    AST_OE_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n_s)
      !alt_fn_en[i] |=> !rst_pin_oe[i]); // R2
    AST_PIN_LOW_WHEN_SRC: assert property (@(posedge clk) disable iff (!rst_n_s)
      src_act[i] |=> !rst_pin_o[i]); // R3
  end

  assign rst_pin_o  = ~asserted;
  assign rst_pin_oe = oe_q;
endmodule

// File: tb/prg_port_reset_tb.sv
`timescale 1ns/1ps
module prg_port_reset_tb;
  localparam int NP  = 3;
  localparam int MIN = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic [NP-1:0] slot_pwr_on, pwr_good, hot_reset, alt_fn_en;
  logic [NP-1:0] rst_pin_o, rst_pin_oe;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  typedef struct {
    int    at;
    int    port;
    bit    pin;
    bit    use_oe;
    bit    oe;
    string tag;
  } exp_t;
  exp_t sb[$];

  prg_port_reset #(.NUM_PORTS(NP), .MIN_ASSERT_CYCLES(MIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .slot_pwr_on(slot_pwr_on),
    .pwr_good(pwr_good), .hot_reset(hot_reset), .alt_fn_en(alt_fn_en),
    .rst_pin_o(rst_pin_o), .rst_pin_oe(rst_pin_oe)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int dly, input int p, input bit pin,
                      input bit use_oe, input bit oe, input string tag);
    exp_t e;
    e.at = cyc + dly; e.port = p; e.pin = pin;
    e.use_oe = use_oe; e.oe = oe; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic direct(input bit act, input bit expv, input string tag, input string what);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, expv);
    end
  endtask

  // monitor: compare scoreboard items in the cycle they are due
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      tests++;
      if (e.at != cyc || rst_pin_o[e.port] !== e.pin ||
          (e.use_oe && rst_pin_oe[e.port] !== e.oe)) begin
        fails++;
        $display("FAIL %s port %0d cycle %0d: pin=%0b oe=%0b expected pin=%0b oe=%0b (due %0d)",
                 e.tag, e.port, cyc, rst_pin_o[e.port], rst_pin_oe[e.port],
                 e.pin, e.oe, e.at);
      end
    end
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'd0;
    slot_pwr_on = '1; pwr_good = '1; hot_reset = '0; alt_fn_en = '0;
    step(3);
    for (int p = 0; p < NP; p++) begin
      direct(rst_pin_o[p], 1'b0, "R1", "pin during reset");
      direct(rst_pin_oe[p], 1'b0, "R1", "oe during reset");
    end
    rst_n = 1'b1;
    step(MIN + 6);
    for (int p = 0; p < NP; p++) push(1, p, 1'b1, 1'b1, 1'b0, "R1");
    step(2);

    // R2: output enable, R10 independence
    alt_fn_en[0] = 1'b1;
    push(1, 0, 1'b1, 1'b1, 1'b1, "R2");
    push(1, 1, 1'b1, 1'b1, 1'b0, "R10");
    step(2);
    alt_fn_en = '1;
    push(1, 2, 1'b1, 1'b1, 1'b1, "R2");
    step(2);

    // R3 / R9: long hold in mode 0
    slot_pwr_on[0] = 1'b0;
    push(1, 0, 1'b0, 1'b0, 1'b0, "R3");
    push(1, 1, 1'b1, 1'b0, 1'b0, "R10");
    push(15, 0, 1'b0, 1'b0, 1'b0, "R3");
    step(20);
    slot_pwr_on[0] = 1'b1;
    push(1, 0, 1'b1, 1'b1, 1'b1, "R9");
    step(3);

    // R7: one-cycle pulse on port 1
    slot_pwr_on[1] = 1'b0;
    push(1, 1, 1'b0, 1'b0, 1'b0, "R3");
    push(MIN + 1, 1, 1'b0, 1'b0, 1'b0, "R7");
    push(MIN + 2, 1, 1'b1, 1'b0, 1'b0, "R7");
    step(1);
    slot_pwr_on[1] = 1'b1;
    step(MIN + 4);

    // R8: source released as the counter empties
    slot_pwr_on[2] = 1'b0;
    push(1, 2, 1'b0, 1'b0, 1'b0, "R8");
    push(MIN + 1, 2, 1'b0, 1'b0, 1'b0, "R8");
    push(MIN + 2, 2, 1'b1, 1'b0, 1'b0, "R8");
    step(MIN + 1);
    slot_pwr_on[2] = 1'b1;
    step(4);

    // R4: power-good mode
    mode_sel = 2'd1;
    step(2);
    pwr_good[2] = 1'b0;
    push(2, 2, 1'b1, 1'b0, 1'b0, "R4");
    push(3, 2, 1'b0, 1'b0, 1'b0, "R4");
    step(20);
    pwr_good[2] = 1'b1;
    push(2, 2, 1'b0, 1'b0, 1'b0, "R4");
    push(3, 2, 1'b1, 1'b0, 1'b0, "R4");
    step(4);
    slot_pwr_on[0] = 1'b0;
    push(1, 0, 1'b1, 1'b0, 1'b0, "R4");
    push(3, 0, 1'b1, 1'b0, 1'b0, "R4");
    step(4);
    slot_pwr_on[0] = 1'b1;
    step(2);

    // R5: hot-reset mode
    mode_sel = 2'd2;
    step(2);
    hot_reset[1] = 1'b1;
    push(2, 1, 1'b1, 1'b0, 1'b0, "R5");
    push(3, 1, 1'b0, 1'b0, 1'b0, "R5");
    push(3, 0, 1'b1, 1'b0, 1'b0, "R10");
    step(20);
    hot_reset[1] = 1'b0;
    push(2, 1, 1'b0, 1'b0, 1'b0, "R5");
    push(3, 1, 1'b1, 1'b0, 1'b0, "R5");
    step(4);
    hot_reset[0] = 1'b1;
    push(3, 0, 1'b0, 1'b0, 1'b0, "R5");
    push(MIN + 3, 0, 1'b0, 1'b0, 1'b0, "R7");
    push(MIN + 4, 0, 1'b1, 1'b0, 1'b0, "R7");
    step(1);
    hot_reset[0] = 1'b0;
    step(MIN + 6);

    // R6: spare encoding behaves as mode 0
    mode_sel = 2'd3;
    step(2);
    slot_pwr_on[2] = 1'b0;
    push(1, 2, 1'b0, 1'b0, 1'b0, "R6");
    step(15);
    slot_pwr_on[2] = 1'b1;
    push(1, 2, 1'b1, 1'b0, 1'b0, "R6");
    step(3);

    // R11: pin value follows reset with output disabled
    mode_sel = 2'd0;
    alt_fn_en[0] = 1'b0;
    push(1, 0, 1'b1, 1'b1, 1'b0, "R11");
    step(2);
    slot_pwr_on[0] = 1'b0;
    push(1, 0, 1'b0, 1'b1, 1'b0, "R11");
    step(MIN + 4);
    slot_pwr_on[0] = 1'b1;
    push(1, 0, 1'b1, 1'b1, 1'b0, "R11");
    step(4);

    while (sb.size() > 0) step(1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule